// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node side of a directory-based cache coherence scheme for a small multiprocessor that has no shared bus. For every memory block it owns, it keeps a full-map entry. The entry holds a presence bit for each node and a dirty flag. Requesting nodes send it read-miss, write-miss and writeback packets. The controller looks up the entry and answers with one of three reply kinds: plain data, the identity of the node that holds the modified copy, or data together with the list of other sharers that the requester must invalidate. When a block is modified and another node wants to write it, the controller sends an intervention to the current owner.

Transactions that need a later message to finish mark the entry busy: a read of a dirty block waits for the owner's data, and a write to a dirty block waits for the owner's revise message. While the entry is busy, every new request to that block is refused with a NACK so that the requester retries. This keeps the writes to that block in a single order. The block data itself is modelled as one small word per block, held inside the controller.

Top module: `dir_home_ctrl`

## Requirements
- R1: During and after reset every entry has no presence bits, dirty clear and busy clear, and the data word of block b equals b. No reply or intervention is valid during reset or in the first cycle after it.
- R2: A read (request type 0) from node x to a block that is clean and not busy gives a data reply (reply type 0) to x carrying the block word, and sets presence bit x.
- R3: A read from node x to a dirty, non-busy block gives an owner reply (type 1) to x, with the owner's ID on rsp_node, and marks the block busy. An owner-data message (type 3) from that owner then stores its word, clears dirty, sets bit x, keeps the owner's bit and clears busy. It produces no reply.
- R4: A write (type 1) from node x to a clean, non-busy block gives a data-plus-vector reply (type 2) to x. The reply carries the block word and the presence vector with bit x removed, and the vector is empty when x was the only sharer. Afterwards only bit x is present and dirty is set.
- R5: A write from node x to a dirty, non-busy block produces no reply. It sends an intervention to owner y (iv_dst = y, iv_req = x), leaves only bit x present with dirty set, and marks the block busy until a revise message (type 4) from y arrives.
- R6: A writeback (type 2) to a non-busy block stores its word, clears all presence bits and dirty, and gives a writeback acknowledge (type 4) to the sender.
- R7: Any read, write or writeback to a busy block gives a NACK (type 3) to the sender and leaves the entry and the data word unchanged.
- R8: A completion message (type 3 or 4) is ignored, with no reply and no state change, unless the block is busy, the message kind matches the pending transaction and the sender is the node that transaction waits on.
- R9: Whenever an entry is dirty, exactly one of its presence bits is set.
- R10: Each reply or intervention is valid for exactly the one cycle after the clock edge that accepted its request. It carries the request's block on rsp_block or iv_block. rsp_data is zero except in reply types 0 and 2, rsp_vec is zero except in type 2, and rsp_node is zero except in type 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming packet valid this cycle |
| req_type | input | 3 | 0 read, 1 write, 2 writeback, 3 owner data, 4 revise |
| req_src | input | 2 | Sending node ID |
| req_block | input | 4 | Block number |
| req_data | input | 8 | Data word (writeback, owner data) |
| rsp_valid | output | 1 | Reply valid |
| rsp_type | output | 3 | 0 data, 1 owner ID, 2 data plus vector, 3 NACK, 4 writeback ack |
| rsp_dst | output | 2 | Destination node of the reply |
| rsp_block | output | 4 | Block the reply concerns |
| rsp_data | output | 8 | Data word of the reply |
| rsp_vec | output | 4 | Sharers to invalidate |
| rsp_node | output | 2 | Owner ID for owner replies |
| iv_valid | output | 1 | Intervention valid |
| iv_dst | output | 2 | Owner receiving the intervention |
| iv_block | output | 4 | Block of the intervention |
| iv_req | output | 2 | Node that asked to write |

## Verification
All replies and interventions come from one register stage, so each result is due in the single cycle that follows the edge where its request was taken. The bench presents a packet for one cycle starting at a falling edge. It drops the packet at the next falling edge and samples every output field at that moment, so the same sample also catches a stray reply to a completion message. The state hidden in the entries, such as the busy state, the owner and a retained data word, is checked through later requests whose replies can only be correct if that state is right. A full-width reply comparison follows every step, which shows that each pulse lasts one cycle.

// File: rtl/dir_pkg.sv
package dir_pkg;
  localparam int NODES  = 4;
  localparam int BLOCKS = 16;
  localparam int DW     = 8;
  localparam int NID_W  = $clog2(NODES);
  localparam int BLK_W  = $clog2(BLOCKS);

  typedef enum logic [2:0] {
    REQ_READ  = 3'd0,
    REQ_WRITE = 3'd1,
    REQ_WBACK = 3'd2,
    REQ_OWNDT = 3'd3,
    REQ_REVISE = 3'd4
  } req_kind_e;

  typedef enum logic [2:0] {
    RSP_DATA  = 3'd0,
    RSP_OWNER = 3'd1,
    RSP_DVEC  = 3'd2,
    RSP_NACK  = 3'd3,
    RSP_WBACK = 3'd4
  } rsp_kind_e;

  typedef struct packed {
    logic [NODES-1:0] pres;
    logic             dirty;
    logic             busy;
    logic             pend_wr;   // pending transaction is a write
    logic [NID_W-1:0] pend_src;  // node whose completion is awaited
    logic [NID_W-1:0] pend_req;  // node that started the transaction
  } dir_entry_t;

  typedef struct packed {
    logic             valid;
    rsp_kind_e        kind;
    logic [NID_W-1:0] dst;
    logic [DW-1:0]    data;
    logic [NODES-1:0] vec;
    logic [NID_W-1:0] node;
  } rsp_pkt_t;

  typedef struct packed {
    logic             valid;
    logic [NID_W-1:0] dst;
    logic [NID_W-1:0] req;
  } iv_pkt_t;

  function automatic logic [NODES-1:0] node_bit(input logic [NID_W-1:0] id);
    logic [NODES-1:0] b;
    b = '0;
    b[id] = 1'b1;
    return b;
  endfunction

  function automatic logic [NID_W-1:0] owner_of(input logic [NODES-1:0] pres);
    logic [NID_W-1:0] o;
    o = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (pres[i]) o = NID_W'(i);
    end
    return o;
  endfunction

  function automatic logic [NODES-1:0] other_sharers(input logic [NODES-1:0] pres,
                                                     input logic [NID_W-1:0] id);
    return pres & ~node_bit(id);
  endfunction

  function automatic logic [DW-1:0] init_word(input int blk);
    return DW'(blk);
  endfunction
endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] idx,
  input  logic             ent_we,
  input  dir_entry_t       ent_wd,
  input  logic             mem_we,
  input  logic [DW-1:0]    mem_wd,
  output dir_entry_t       ent_rd,
  output logic [DW-1:0]    mem_rd
);
  dir_entry_t    ent_q [BLOCKS];
  logic [DW-1:0] mem_q [BLOCKS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCKS; b++) begin
        ent_q[b] <= '0;
        mem_q[b] <= init_word(b);
      end
    end else begin
      if (ent_we) ent_q[idx] <= ent_wd;
      if (mem_we) mem_q[idx] <= mem_wd;
    end
  end

  assign ent_rd = ent_q[idx];
  assign mem_rd = mem_q[idx];

  // R9
  dirty_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_rd.dirty |-> ($countones(ent_rd.pres) == 1));
endmodule

// File: rtl/dir_decide.sv
module dir_decide
  import dir_pkg::*;
(
  input  logic             req_valid,
  input  logic [2:0]       req_type,
  input  logic [NID_W-1:0] req_src,
  input  logic [DW-1:0]    req_data,
  input  dir_entry_t       cur,
  input  logic [DW-1:0]    cur_word,
  output logic             ent_we,
  output dir_entry_t       nxt,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wd,
  output rsp_pkt_t         rsp,
  output iv_pkt_t          iv,
  output logic             nack_evt,
  output logic             done_evt
);
  logic is_req;
  logic done_ok;

  assign is_req = req_valid && (req_type == REQ_READ || req_type == REQ_WRITE ||
                                req_type == REQ_WBACK);
  assign nack_evt = is_req && cur.busy;

  always_comb begin
    done_ok = 1'b0;
    if (req_valid && cur.busy && req_src == cur.pend_src) begin
      if (req_type == REQ_OWNDT && !cur.pend_wr) done_ok = 1'b1;
      if (req_type == REQ_REVISE && cur.pend_wr) done_ok = 1'b1;
    end
  end
  assign done_evt = done_ok;

  always_comb begin
    ent_we = 1'b0;
    nxt    = cur;
    mem_we = 1'b0;
    mem_wd = req_data;
    rsp    = '0;
    rsp.dst = req_src;
    iv     = '0;
    if (nack_evt) begin
      rsp.valid = 1'b1;
      rsp.kind  = RSP_NACK;
    end else if (is_req) begin
      ent_we = 1'b1;
      unique case (req_type)
        REQ_READ: begin
          rsp.valid = 1'b1;
          if (!cur.dirty) begin
            rsp.kind = RSP_DATA;
            rsp.data = cur_word;
            nxt.pres = cur.pres | node_bit(req_src);
          end else begin
            rsp.kind     = RSP_OWNER;
            rsp.node     = owner_of(cur.pres);
            nxt.busy     = 1'b1;
            nxt.pend_wr  = 1'b0;
            nxt.pend_src = owner_of(cur.pres);
            nxt.pend_req = req_src;
          end
        end
        REQ_WRITE: begin
          nxt.pres  = node_bit(req_src);
          nxt.dirty = 1'b1;
          if (!cur.dirty) begin
            rsp.valid = 1'b1;
            rsp.kind  = RSP_DVEC;
            rsp.data  = cur_word;
            rsp.vec   = other_sharers(cur.pres, req_src);
          end else begin
            iv.valid     = 1'b1;
            iv.dst       = owner_of(cur.pres);
            iv.req       = req_src;
            nxt.busy     = 1'b1;
            nxt.pend_wr  = 1'b1;
            nxt.pend_src = owner_of(cur.pres);
            nxt.pend_req = req_src;
          end
        end
        default: begin
          rsp.valid = 1'b1;
          rsp.kind  = RSP_WBACK;
          mem_we    = 1'b1;
          nxt.pres  = '0;
          nxt.dirty = 1'b0;
        end
      endcase
    end else if (done_ok) begin
      ent_we   = 1'b1;
      nxt.busy = 1'b0;
      if (!cur.pend_wr) begin
        mem_we    = 1'b1;
        nxt.dirty = 1'b0;
        nxt.pres  = cur.pres | node_bit(cur.pend_req);
      end
    end
  end

  // R7
  busy_no_write_chk: assert final (!(nack_evt && (ent_we || mem_we)));
endmodule

// File: rtl/dir_out.sv
module dir_out
  import dir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [BLK_W-1:0] req_block,
  input  rsp_pkt_t         rsp_d,
  input  iv_pkt_t          iv_d,
  output rsp_pkt_t         rsp_q,
  output iv_pkt_t          iv_q,
  output logic [BLK_W-1:0] blk_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q <= '0;
      iv_q  <= '0;
      blk_q <= '0;
    end else begin
      rsp_q <= rsp_d;
      iv_q  <= iv_d;
      blk_q <= req_block;
    end
  end

  // R10
  reply_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_q.valid || iv_q.valid) |-> $past(req_valid));

  // R10
  reply_not_with_iv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_q.valid && iv_q.valid));
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_type,
  input  logic [NID_W-1:0] req_src,
  input  logic [BLK_W-1:0] req_block,
  input  logic [DW-1:0]    req_data,
  output logic             rsp_valid,
  output logic [2:0]       rsp_type,
  output logic [NID_W-1:0] rsp_dst,
  output logic [BLK_W-1:0] rsp_block,
  output logic [DW-1:0]    rsp_data,
  output logic [NODES-1:0] rsp_vec,
  output logic [NID_W-1:0] rsp_node,
  output logic             iv_valid,
  output logic [NID_W-1:0] iv_dst,
  output logic [BLK_W-1:0] iv_block,
  output logic [NID_W-1:0] iv_req
);
  dir_entry_t    cur_ent, nxt_ent;
  logic [DW-1:0] cur_word, mem_wd;
  logic          ent_we, mem_we;
  rsp_pkt_t      rsp_d, rsp_q;
  iv_pkt_t       iv_d, iv_q;
  logic [BLK_W-1:0] blk_q;
  logic          nack_evt, done_evt;

  dir_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (req_block),
    .ent_we (ent_we),
    .ent_wd (nxt_ent),
    .mem_we (mem_we),
    .mem_wd (mem_wd),
    .ent_rd (cur_ent),
    .mem_rd (cur_word)
  );

  dir_decide u_decide (
    .req_valid (req_valid),
    .req_type  (req_type),
    .req_src   (req_src),
    .req_data  (req_data),
    .cur       (cur_ent),
    .cur_word  (cur_word),
    .ent_we    (ent_we),
    .nxt       (nxt_ent),
    .mem_we    (mem_we),
    .mem_wd    (mem_wd),
    .rsp       (rsp_d),
    .iv        (iv_d),
    .nack_evt  (nack_evt),
    .done_evt  (done_evt)
  );

  dir_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_block (req_block),
    .rsp_d     (rsp_d),
    .iv_d      (iv_d),
    .rsp_q     (rsp_q),
    .iv_q      (iv_q),
    .blk_q     (blk_q)
  );

  assign rsp_valid = rsp_q.valid;
  assign rsp_type  = rsp_q.kind;
  assign rsp_dst   = rsp_q.dst;
  assign rsp_block = blk_q;
  assign rsp_data  = rsp_q.data;
  assign rsp_vec   = rsp_q.vec;
  assign rsp_node  = rsp_q.node;
  assign iv_valid  = iv_q.valid;
  assign iv_dst    = iv_q.dst;
  assign iv_block  = blk_q;
  assign iv_req    = iv_q.req;

  // R7
  nack_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_type == RSP_NACK) |-> $past(cur_ent.busy));

  // R3
  owner_reply_needs_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_type == RSP_OWNER) |-> $past(cur_ent.dirty));

  // R5
  iv_needs_dirty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iv_valid |-> $past(cur_ent.dirty && req_type == REQ_WRITE));

  // R8
  done_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !cur_ent.busy || $past(req_block) != req_block);
endmodule

// File: tb/dir_home_ctrl_test.sv
module dir_home_ctrl_test;
  typedef struct packed {
    logic [2:0] typ;
    logic [1:0] src;
    logic [3:0] blk;
    logic [7:0] dat;
    logic       rv;
    logic [2:0] rt;
    logic [7:0] rd;
    logic [3:0] rvec;
    logic [1:0] rnode;
    logic       ivv;
    logic [1:0] ivd;
    logic [1:0] ivr;
    logic [3:0] rq;
  } vec_t;

  function automatic vec_t mk(int typ, int src, int blk, int dat, int rv, int rt,
                              int rd, int rvec, int rnode, int ivv, int ivd,
                              int ivr, int rq);
    vec_t v;
    v.typ = 3'(typ); v.src = 2'(src); v.blk = 4'(blk); v.dat = 8'(dat);
    v.rv = 1'(rv); v.rt = 3'(rt); v.rd = 8'(rd); v.rvec = 4'(rvec);
    v.rnode = 2'(rnode); v.ivv = 1'(ivv); v.ivd = 2'(ivd); v.ivr = 2'(ivr);
    v.rq = 4'(rq);
    return v;
  endfunction

  localparam int NV = 27;
  // fields: type src blk data | rsp valid type data vec node | iv valid dst req | req tag
  localparam vec_t TBL [NV] = '{
    mk(0,0,5,0,     1,0,5,0,0,     0,0,0, 2),  // R2 read clean
    mk(0,1,5,0,     1,0,5,0,0,     0,0,0, 2),  // R2
    mk(0,3,5,0,     1,0,5,0,0,     0,0,0, 2),  // R2
    mk(1,3,5,0,     1,2,5,3,0,     0,0,0, 4),  // R4 sharers 0,1
    mk(0,2,5,0,     1,1,0,0,3,     0,0,0, 3),  // R3 owner is 3
    mk(1,0,5,0,     1,3,0,0,0,     0,0,0, 7),  // R7 busy
    mk(3,1,5,8'h77, 0,0,0,0,0,     0,0,0, 8),  // R8 wrong sender
    mk(4,3,5,0,     0,0,0,0,0,     0,0,0, 8),  // R8 wrong kind
    mk(3,3,5,8'h77, 0,0,0,0,0,     0,0,0, 3),  // R3 owner data
    mk(0,0,5,0,     1,0,8'h77,0,0, 0,0,0, 3),  // R3 memory updated
    mk(1,2,5,0,     1,2,8'h77,9,0, 0,0,0, 4),  // R4 sharers 0,3 kept
    mk(1,1,5,0,     0,0,0,0,0,     1,2,1, 5),  // R5 intervention
    mk(0,0,5,0,     1,3,0,0,0,     0,0,0, 7),  // R7
    mk(4,2,5,0,     0,0,0,0,0,     0,0,0, 5),  // R5 revise
    mk(0,3,5,0,     1,1,0,0,1,     0,0,0, 5),  // R5 owner now 1
    mk(3,1,5,8'h42, 0,0,0,0,0,     0,0,0, 3),  // R3
    mk(2,1,5,8'h99, 1,4,0,0,0,     0,0,0, 6),  // R6 writeback
    mk(1,0,5,0,     1,2,8'h99,0,0, 0,0,0, 6),  // R6 cleared, word kept
    mk(0,2,9,0,     1,0,9,0,0,     0,0,0, 2),  // R2
    mk(1,2,9,0,     1,2,9,0,0,     0,0,0, 4),  // R4 sole sharer, empty vector
    mk(4,2,9,0,     0,0,0,0,0,     0,0,0, 8),  // R8 not busy
    mk(0,1,9,0,     1,1,0,0,2,     0,0,0, 8),  // R8 state unchanged
    mk(0,3,0,0,     1,0,0,0,0,     0,0,0, 1),  // R1 init word
    mk(0,0,15,0,    1,0,15,0,0,    0,0,0, 1),  // R1 init word
    mk(2,2,9,8'hAA, 1,3,0,0,0,     0,0,0, 7),  // R7 writeback refused
    mk(3,2,9,8'h10, 0,0,0,0,0,     0,0,0, 3),  // R3
    mk(0,0,9,0,     1,0,8'h10,0,0, 0,0,0, 7)   // R7 word not overwritten
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_type = '0;
  logic [1:0] req_src = '0;
  logic [3:0] req_block = '0;
  logic [7:0] req_data = '0;
  logic       rsp_valid;
  logic [2:0] rsp_type;
  logic [1:0] rsp_dst;
  logic [3:0] rsp_block;
  logic [7:0] rsp_data;
  logic [3:0] rsp_vec;
  logic [1:0] rsp_node;
  logic       iv_valid;
  logic [1:0] iv_dst;
  logic [3:0] iv_block;
  logic [1:0] iv_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dir_home_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_src(req_src), .req_block(req_block), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_dst(rsp_dst),
    .rsp_block(rsp_block), .rsp_data(rsp_data), .rsp_vec(rsp_vec),
    .rsp_node(rsp_node), .iv_valid(iv_valid), .iv_dst(iv_dst),
    .iv_block(iv_block), .iv_req(iv_req)
  );

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // drive one packet for one cycle; on return the outputs for it are stable
  task automatic send(int typ, int src, int blk, int dat);
    req_valid = 1'b1;
    req_type  = 3'(typ);
    req_src   = 2'(src);
    req_block = 4'(blk);
    req_data  = 8'(dat);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_vec(int i, vec_t v);
    string rq;
    rq = $sformatf("R%0d vec%0d", v.rq, i);
    chk(rq, "rsp_valid", 32'(rsp_valid), 32'(v.rv));
    if (v.rv) begin
      chk(rq, "rsp_type", 32'(rsp_type), 32'(v.rt));
      chk(rq, "rsp_dst", 32'(rsp_dst), 32'(v.src));
      chk(rq, "rsp_block", 32'(rsp_block), 32'(v.blk));
      chk(rq, "rsp_data", 32'(rsp_data), 32'(v.rd));
      chk(rq, "rsp_vec", 32'(rsp_vec), 32'(v.rvec));
      chk(rq, "rsp_node", 32'(rsp_node), 32'(v.rnode));
    end
    chk(rq, "iv_valid", 32'(iv_valid), 32'(v.ivv));
    if (v.ivv) begin
      chk(rq, "iv_dst", 32'(iv_dst), 32'(v.ivd));
      chk(rq, "iv_req", 32'(iv_req), 32'(v.ivr));
      chk(rq, "iv_block", 32'(iv_block), 32'(v.blk));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle under reset
    chk("R1", "rsp_valid in reset", 32'(rsp_valid), 0);
    chk("R1", "iv_valid in reset", 32'(iv_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      send(TBL[i].typ, TBL[i].src, TBL[i].blk, TBL[i].dat);
      check_vec(i, TBL[i]);
    end

    // R10: a reply lasts one cycle only
    send(0, 1, 3, 0);
    chk("R10", "reply present", 32'(rsp_valid), 1);
    @(negedge clk);
    chk("R10", "reply gone next cycle", 32'(rsp_valid), 0);

    // R1: reset in mid-run clears dirty block 5 and restores its word
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    send(0, 1, 5, 0);
    chk("R1", "read after reset kind", 32'(rsp_type), 0);
    chk("R1", "read after reset word", 32'(rsp_data), 5);
    // R9: the writer becomes the sole owner
    send(1, 2, 5, 0);
    chk("R9", "vector excludes writer", 32'(rsp_vec), 32'h2);
    send(0, 0, 5, 0);
    chk("R9", "owner reply node", 32'(rsp_node), 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule